// File: doc/BRIEF.md
# Time-Slotted Radio Scheduler with Channel Hopping

This block keeps the slot schedule of one node in a synchronised, low-power mesh network. Time runs in slots of a nominal number of clock ticks, and slots repeat in a frame whose length in slots is set at an input. A small table holds one entry per slot. Each entry names what the node does in that slot: sleep, transmit, listen, or service the local sensor. It also names which of the node's two parent links the slot belongs to. From the entry the block drives a radio enable, a sensor enable, the parent targeted and the radio channel.

The channel is one of 16. It is read from a fixed pseudo-random ordering of all 16 channels. The position in that ordering is the targeted link's own start offset plus a slot number that never resets. Links with different offsets therefore sit on different channels in the same slot, and each link moves to a new channel from slot to slot. An acknowledgement input reports the outcome of each transmit slot. When a first attempt is not acknowledged, the next transmit slot goes to the other parent. When both parents fail, an error counter counts the event. The acknowledgement also carries a signed timing offset, which stretches or shrinks the next slot by a bounded number of ticks to keep the node aligned with its neighbours.

Top module: `tdma_hop_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `slot_start` is 1 and `slot_idx`, `abs_slot` and `err_count` are 0. `slot_start` is 1 only in the first cycle of each slot. Without correction a slot lasts SLOT_TICKS cycles (default 64).
- R2: `slot_idx` counts up by one per slot and returns to 0 after slot `cfg_frame_len`-1. A frame length of 0 acts as 1. `abs_slot` rises by one every slot and does not return to 0 at the frame boundary.
- R3: A table entry holds a 2-bit action code and a 1-bit link number, written through `wr_*`. The action codes are 0 = sleep, 1 = transmit, 2 = listen and 3 = sensor access. `action` shows the code of the current slot. `radio_en` is 1 only for codes 1 and 2, and `sensor_en` is 1 only for code 3.
- R4: `channel` = H((off + abs_slot) mod 16), with H(i) = (5*i + 3) mod 16. Here off is `cfg_off0` when `tx_parent` is 0 and `cfg_off1` when it is 1.
- R5: `tx_parent` is the entry's link number XOR a redirect bit. The redirect bit is 0 after reset. A missed acknowledgement (`ack_ok`=0) on a first attempt sets the bit to 1 from the next slot onward.
- R6: A good acknowledgement clears the redirect bit from the next slot. A missed acknowledgement on a redirected attempt clears it and adds one to `err_count`, starting in the cycle after the acknowledgement.
- R7: `err_count` stops at 255 and holds there.
- R8: An accepted acknowledgement makes the next slot SLOT_TICKS + c cycles long. c is `ack_offset`, read as a signed value and clamped to ±SLOT_TICKS/8 (±8 by default). Only that one slot is affected.
- R9: An acknowledgement in a slot whose action is not transmit changes nothing. In a transmit slot only the first acknowledgement is accepted, and any later ones in the same slot change nothing.
- R10: An acknowledgement in the last cycle of a slot takes effect on the slot that starts in the next cycle: its length, its `tx_parent` and its `channel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frame_len | input | 6 | Frame length in slots |
| cfg_off0 | input | 4 | Hop start offset of parent link 0 |
| cfg_off1 | input | 4 | Hop start offset of parent link 1 |
| wr_en | input | 1 | Schedule table write strobe |
| wr_slot | input | 5 | Slot entry to write |
| wr_action | input | 2 | Action code to write |
| wr_link | input | 1 | Link number to write |
| ack_valid | input | 1 | Acknowledgement outcome present |
| ack_ok | input | 1 | 1 = acknowledged, 0 = missed |
| ack_offset | input | 8 | Signed timing correction in ticks |
| slot_start | output | 1 | First cycle of a slot |
| slot_idx | output | 5 | Slot position in the frame |
| abs_slot | output | 16 | Free-running slot number |
| action | output | 2 | Action code of the current slot |
| radio_en | output | 1 | Radio on (transmit or listen) |
| sensor_en | output | 1 | Sensor access slot |
| tx_parent | output | 1 | Parent link targeted this slot |
| channel | output | 4 | Radio channel this slot |
| err_count | output | 8 | Saturating double-failure count |

## Verification
The collision that matters is an acknowledgement arriving in the same cycle as a slot boundary. In that cycle the redirect decision, the clamped length correction and the error update all have to land in the slot that is just starting. Random transmit slots place their acknowledgement on the final tick about a quarter of the time. A reference model predicts the next slot's measured length, target parent, channel and error count, and all four are compared at the next slot start. A second collision also comes up: a redirected attempt fails while the counter is already at its limit. A long run of missed acknowledgements provokes it and confirms that the counter holds at 255.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        ACT_SLEEP  = 2'd0,
        ACT_TX     = 2'd1,
        ACT_LISTEN = 2'd2,
        ACT_SENSE  = 2'd3
    } act_e;

    typedef struct packed {
        act_e act;
        logic link;
    } slot_entry_t;

    localparam int          CHAN_W  = 4;
    localparam logic [7:0]  HOP_MUL = 8'd5;
    localparam logic [7:0]  HOP_ADD = 8'd3;

    // Fixed permutation of the 16 channels (odd multiplier keeps it bijective)
    function automatic logic [CHAN_W-1:0] hop_lookup(input logic [CHAN_W-1:0] pos);
        logic [7:0] prod;
        prod = 8'(pos) * HOP_MUL + HOP_ADD;
        return prod[CHAN_W-1:0];
    endfunction

    // Position in the permutation: link offset plus slot number, mod 16
    function automatic logic [CHAN_W-1:0] hop_pos(input logic [CHAN_W-1:0] off,
                                                  input logic [CHAN_W-1:0] slot_lsb);
        return off + slot_lsb;
    endfunction

endpackage

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
    parameter int SLOT_TICKS = 64,
    parameter int MAX_SLOTS  = 32,
    parameter int ABS_W      = 16,
    localparam int IDX_W     = $clog2(MAX_SLOTS),
    localparam int TICK_W    = $clog2(SLOT_TICKS + SLOT_TICKS/8 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W:0]    frame_len,
    input  logic [TICK_W-1:0] next_len,
    output logic              slot_end,
    output logic              slot_start,
    output logic [IDX_W-1:0]  slot_idx,
    output logic [ABS_W-1:0]  abs_slot
);
    logic [TICK_W-1:0] tick;
    logic [TICK_W-1:0] cur_len;
    logic [IDX_W:0]    idx_inc;

    assign slot_end   = (tick == cur_len - TICK_W'(1));
    assign slot_start = (tick == '0);
    assign idx_inc    = {1'b0, slot_idx} + (IDX_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick     <= '0;
            cur_len  <= TICK_W'(SLOT_TICKS);
            slot_idx <= '0;
            abs_slot <= '0;
        end else if (slot_end) begin
            tick     <= '0;
            cur_len  <= next_len;
            slot_idx <= (idx_inc >= frame_len) ? '0 : idx_inc[IDX_W-1:0];
            abs_slot <= abs_slot + ABS_W'(1);
        end else begin
            tick <= tick + TICK_W'(1);
        end
    end
endmodule

// File: rtl/tdma_sched_ram.sv
module tdma_sched_ram import tdma_pkg::*; #(
    parameter int MAX_SLOTS = 32,
    localparam int IDX_W    = $clog2(MAX_SLOTS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  slot_entry_t      wdata,
    input  logic [IDX_W-1:0] raddr,
    output slot_entry_t      rdata
);
    slot_entry_t mem [MAX_SLOTS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tdma_link_ctrl.sv
module tdma_link_ctrl #(
    parameter int SLOT_TICKS = 64,
    parameter int OFS_W      = 8,
    parameter int ERR_W      = 8,
    localparam int TICK_W    = $clog2(SLOT_TICKS + SLOT_TICKS/8 + 1),
    localparam int LIM       = SLOT_TICKS / 8,
    localparam int ADJ_W     = $clog2(LIM + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    slot_end,
    input  logic                    slot_is_tx,
    input  logic                    ack_valid,
    input  logic                    ack_ok,
    input  logic signed [OFS_W-1:0] ack_ofs,
    output logic                    slot_redir,
    output logic [TICK_W-1:0]       next_len,
    output logic [ERR_W-1:0]        err_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic                    redir_pend, redir_n;
    logic                    taken, take;
    logic signed [ADJ_W-1:0] adj, adj_n, ofs_clamped;
    int                      ofs_i;

    always_comb begin
        ofs_i = int'(ack_ofs);
        if (ofs_i > LIM)       ofs_clamped = ADJ_W'(LIM);
        else if (ofs_i < -LIM) ofs_clamped = ADJ_W'(-LIM);
        else                   ofs_clamped = ADJ_W'(ofs_i);
    end

    assign take     = ack_valid && slot_is_tx && !taken;
    assign redir_n  = take ? (ack_ok ? 1'b0 : ~slot_redir) : redir_pend;
    assign adj_n    = take ? ofs_clamped : adj;
    assign next_len = TICK_W'(SLOT_TICKS + int'(adj_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_pend <= 1'b0;
            slot_redir <= 1'b0;
            taken      <= 1'b0;
            adj        <= '0;
        end else if (slot_end) begin
            redir_pend <= redir_n;
            slot_redir <= redir_n;
            taken      <= 1'b0;
            adj        <= '0;
        end else begin
            redir_pend <= redir_n;
            adj        <= adj_n;
            taken      <= taken | take;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_count <= '0;
        else if (take && !ack_ok && slot_redir && err_count != ERR_MAX)
            err_count <= err_count + ERR_W'(1);
    end
endmodule

// File: rtl/tdma_hop_sched.sv
module tdma_hop_sched import tdma_pkg::*; #(
    parameter int SLOT_TICKS = 64,
    parameter int MAX_SLOTS  = 32,
    parameter int ABS_W      = 16,
    parameter int OFS_W      = 8,
    parameter int ERR_W      = 8,
    localparam int IDX_W     = $clog2(MAX_SLOTS),
    localparam int TICK_W    = $clog2(SLOT_TICKS + SLOT_TICKS/8 + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IDX_W:0]          cfg_frame_len,
    input  logic [CHAN_W-1:0]       cfg_off0,
    input  logic [CHAN_W-1:0]       cfg_off1,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_slot,
    input  logic [1:0]              wr_action,
    input  logic                    wr_link,
    input  logic                    ack_valid,
    input  logic                    ack_ok,
    input  logic signed [OFS_W-1:0] ack_offset,
    output logic                    slot_start,
    output logic [IDX_W-1:0]        slot_idx,
    output logic [ABS_W-1:0]        abs_slot,
    output logic [1:0]              action,
    output logic                    radio_en,
    output logic                    sensor_en,
    output logic                    tx_parent,
    output logic [CHAN_W-1:0]       channel,
    output logic [ERR_W-1:0]        err_count
);
    logic                    slot_end;
    logic [TICK_W-1:0]       next_len;
    logic                    slot_redir;
    slot_entry_t             ent;
    slot_entry_t             wr_ent;
    logic [1:0][CHAN_W-1:0]  link_off;

    assign wr_ent   = '{act: act_e'(wr_action), link: wr_link};
    assign link_off = {cfg_off1, cfg_off0};

    tdma_slot_timer #(.SLOT_TICKS(SLOT_TICKS), .MAX_SLOTS(MAX_SLOTS), .ABS_W(ABS_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_len  (cfg_frame_len),
        .next_len   (next_len),
        .slot_end   (slot_end),
        .slot_start (slot_start),
        .slot_idx   (slot_idx),
        .abs_slot   (abs_slot)
    );

    tdma_sched_ram #(.MAX_SLOTS(MAX_SLOTS)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_slot),
        .wdata (wr_ent),
        .raddr (slot_idx),
        .rdata (ent)
    );

    tdma_link_ctrl #(.SLOT_TICKS(SLOT_TICKS), .OFS_W(OFS_W), .ERR_W(ERR_W)) u_link (
        .clk        (clk),
        .rst        (rst),
        .slot_end   (slot_end),
        .slot_is_tx (ent.act == ACT_TX),
        .ack_valid  (ack_valid),
        .ack_ok     (ack_ok),
        .ack_ofs    (ack_offset),
        .slot_redir (slot_redir),
        .next_len   (next_len),
        .err_count  (err_count)
    );

    assign action    = ent.act;
    assign radio_en  = (ent.act == ACT_TX) || (ent.act == ACT_LISTEN);
    assign sensor_en = (ent.act == ACT_SENSE);
    assign tx_parent = ent.link ^ slot_redir;
    assign channel   = hop_lookup(hop_pos(link_off[tx_parent], abs_slot[CHAN_W-1:0]));
endmodule

// File: rtl/tdma_hop_sched_chk.sv
module tdma_hop_sched_chk #(
    parameter int MAX_SLOTS = 32,
    parameter int ABS_W     = 16,
    parameter int ERR_W     = 8,
    localparam int IDX_W    = $clog2(MAX_SLOTS)
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_start,
    input logic [IDX_W-1:0] slot_idx,
    input logic [ABS_W-1:0] abs_slot,
    input logic             radio_en,
    input logic             sensor_en,
    input logic             ack_valid,
    input logic             ack_ok,
    input logic [ERR_W-1:0] err_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);

    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !slot_start |-> $stable(slot_idx));

    assert_abs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !slot_start |-> $stable(abs_slot));

    assert_enable_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(radio_en && sensor_en));

    assert_err_step_R6: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |-> (err_count == $past(err_count) + ERR_W'(1)));

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |-> $past(ack_valid && !ack_ok));

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (err_count == ERR_MAX) |=> (err_count == ERR_MAX));
endmodule

bind tdma_hop_sched tdma_hop_sched_chk #(
    .MAX_SLOTS(MAX_SLOTS), .ABS_W(ABS_W), .ERR_W(ERR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .abs_slot   (abs_slot),
    .radio_en   (radio_en),
    .sensor_en  (sensor_en),
    .ack_valid  (ack_valid),
    .ack_ok     (ack_ok),
    .err_count  (err_count)
);

// File: tb/sim_tdma_hop_sched.sv
`timescale 1ns/1ps
module sim_tdma_hop_sched;
    localparam int ST  = 64;
    localparam int MS  = 32;
    localparam int LIM = ST / 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  cfg_frame_len;
    logic [3:0]  cfg_off0, cfg_off1;
    logic        wr_en;
    logic [4:0]  wr_slot;
    logic [1:0]  wr_action;
    logic        wr_link;
    logic        ack_valid, ack_ok;
    logic signed [7:0] ack_offset;
    logic        slot_start;
    logic [4:0]  slot_idx;
    logic [15:0] abs_slot;
    logic [1:0]  action;
    logic        radio_en, sensor_en, tx_parent;
    logic [3:0]  channel;
    logic [7:0]  err_count;

    tdma_hop_sched u0 (
        .clk(clk), .rst(rst), .cfg_frame_len(cfg_frame_len),
        .cfg_off0(cfg_off0), .cfg_off1(cfg_off1),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_action(wr_action), .wr_link(wr_link),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .ack_offset(ack_offset),
        .slot_start(slot_start), .slot_idx(slot_idx), .abs_slot(abs_slot),
        .action(action), .radio_en(radio_en), .sensor_en(sensor_en),
        .tx_parent(tx_parent), .channel(channel), .err_count(err_count)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int s_act [MS];
    int s_lnk [MS];
    int m_idx, m_abs, m_redir, m_pend, m_err, m_len, frame;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hop(int i);
        return (5 * i + 3) % 16;
    endfunction

    function automatic int clampv(int v);
        return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
    endfunction

    task automatic do_reset();
        rst = 1'b1; ack_valid = 1'b0; ack_ok = 1'b0; ack_offset = '0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < MS; i++) begin
            wr_en = 1'b1; wr_slot = 5'(i); wr_action = 2'(s_act[i]); wr_link = s_lnk[i][0];
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_idx = 0; m_abs = 0; m_redir = 0; m_pend = 0; m_err = 0; m_len = ST;
        chk("R1 reset slot_start", int'(slot_start), 1);
        chk("R1 reset slot_idx", int'(slot_idx), 0);
        chk("R1 reset abs_slot", int'(abs_slot), 0);
        chk("R1 reset err_count", int'(err_count), 0);
    endtask

    // mode 0: random acks; mode 1: every transmit slot missed on tick 3
    task automatic run_slots(int n, int mode);
        for (int s = 0; s < n; s++) begin
            int act, tgt, off, t1, t2, ok1, ok2, of1, of2, taken, adj, cur_len;
            string ltag;
            act = s_act[m_idx];
            tgt = s_lnk[m_idx] ^ m_redir;
            off = tgt ? int'(cfg_off1) : int'(cfg_off0);
            chk("R1 slot_start", int'(slot_start), 1);
            chk("R2 slot_idx", int'(slot_idx), m_idx);
            chk("R2 abs_slot", int'(abs_slot), m_abs % 65536);
            chk("R3 action", int'(action), act);
            chk("R3 radio_en", int'(radio_en), int'(act == 1 || act == 2));
            chk("R3 sensor_en", int'(sensor_en), int'(act == 3));
            chk("R5 tx_parent", int'(tx_parent), tgt);
            chk("R4 channel", int'(channel), hop((off + m_abs) % 16));
            chk("R6 R7 err_count", int'(err_count), m_err);

            t1 = -1; t2 = -1; ok1 = 0; ok2 = 0; of1 = 0; of2 = 0;
            ltag = "R8 slot length";
            if (mode == 1) begin
                if (act == 1) t1 = 3;
            end else if (act == 1) begin
                if ($urandom % 100 < 75) begin
                    t1  = ($urandom % 4 == 0) ? m_len - 1 : int'($urandom % m_len);
                    ok1 = int'($urandom % 2);
                    of1 = int'($urandom % 41) - 20;
                    if (t1 == m_len - 1) ltag = "R10 slot length after last-tick ack";
                    if ($urandom % 5 == 0 && t1 < m_len - 1) begin
                        t2  = t1 + 1 + int'($urandom % (m_len - 1 - t1));
                        ok2 = 1 - ok1;
                        of2 = (of1 > 0) ? -20 : 20;
                        ltag = "R9 second ack ignored, slot length";
                    end
                end
            end else if ($urandom % 100 < 30) begin
                t1 = int'($urandom % m_len); ok1 = 0; of1 = 20;
                ltag = "R9 stray ack ignored, slot length";
            end

            taken = 0; adj = 0; cur_len = m_len;
            for (int t = 0; t < 300; t++) begin
                if (t == t1 || t == t2) begin
                    int ok, ofv;
                    ok  = (t == t1) ? ok1 : ok2;
                    ofv = (t == t1) ? of1 : of2;
                    ack_valid = 1'b1; ack_ok = ok[0]; ack_offset = 8'(ofv);
                    if (act == 1 && taken == 0) begin
                        taken = 1;
                        if (ok == 0 && m_redir == 1 && m_err < 255) m_err++;
                        m_pend = (ok == 1) ? 0 : 1 - m_redir;
                        adj = clampv(ofv);
                    end
                end else begin
                    ack_valid = 1'b0;
                end
                @(negedge clk);
                if (slot_start) begin
                    chk(ltag, t + 1, cur_len);
                    break;
                end
            end
            ack_valid = 1'b0;
            m_len   = ST + (taken ? adj : 0);
            m_redir = m_pend;
            m_idx   = (m_idx + 1 >= frame) ? 0 : m_idx + 1;
            m_abs++;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        cfg_off0 = 4'd2; cfg_off1 = 4'd9;
        for (int i = 0; i < MS; i++) begin
            s_act[i] = int'($urandom % 4); s_lnk[i] = int'($urandom % 2);
        end
        s_act[0] = 1; s_lnk[0] = 0;
        s_act[1] = 2; s_lnk[1] = 1;
        s_act[2] = 3; s_lnk[2] = 0;
        s_act[3] = 1; s_lnk[3] = 1;

        // Phase 1: short frame
        frame = 4; cfg_frame_len = 6'(frame);
        do_reset();
        run_slots(60, 0);

        // Phase 2: largest frame, new schedule and offsets
        for (int i = 0; i < MS; i++) begin
            s_act[i] = (i % 3 == 0) ? 1 : int'($urandom % 4); s_lnk[i] = int'($urandom % 2);
        end
        cfg_off0 = 4'd13; cfg_off1 = 4'd5;
        frame = 32; cfg_frame_len = 6'(frame);
        do_reset();
        run_slots(100, 0);

        // Phase 3: frame of one slot, then zero acting as one (no reset)
        frame = 1; cfg_frame_len = 6'(frame);
        run_slots(15, 0);
        frame = 0; cfg_frame_len = 6'(frame);
        run_slots(10, 0);

        // Phase 4: every transmit slot missed until the counter saturates
        for (int i = 0; i < MS; i++) begin
            s_act[i] = 1; s_lnk[i] = 0;
        end
        frame = 8; cfg_frame_len = 6'(frame);
        do_reset();
        run_slots(520, 1);
        chk("R7 err_count saturated", int'(err_count), 255);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule